// File: doc/BRIEF.md
# Re-Reference Prediction Replacement Engine

This block chooses which way of a set-associative cache to evict on a miss, and keeps the replacement state that drives that choice. Every way of every set carries a small prediction counter. A value of zero means the line is expected to be used again very soon. The all-ones value, called distant, means the line is not expected to be used again. Hits move a way's counter toward zero. A fill sets the counter of the refilled way to an insertion value. When a set has no way at the distant value, all its counters are raised together until one of them reaches it.

Two configuration inputs set the policy. `cfg_freq_promote` chooses how a hit is promoted: it either clears the counter or lowers it by one step. `cfg_bimodal_fill` chooses how a fill is inserted: either always one step short of distant, or mostly at distant with the short-of-distant value used only now and then. The cache controller sends hits on one valid/ready channel and misses on another. For each miss it gets back a victim way with a valid/ready handshake, and the insertion write happens when that victim is accepted.

The engine is a three-state machine. IDLE accepts misses and hits. Accepting a miss moves it to SEARCH. SEARCH is one cycle: it reads the set, ages it if that is needed, picks the victim, writes the aged set back, and always moves to OFFER. OFFER presents the victim. It returns to IDLE on the cycle `victim_ready` is high, and that same edge writes the insertion value.

Top module: `rrip_engine`

## Requirements
- R1: After reset every counter of every set holds the distant value 2^M−1 (3 for M=2), `victim_valid` is low and `miss_ready` and `hit_ready` are high.
- R2: When `miss_inval` is zero, the victim is the lowest-numbered way whose counter, after any aging, equals the distant value.
- R3: When no way of the missed set is at the distant value, every counter of the set is raised by the same amount, which is distant minus the largest counter in the set. The raised values are stored, and they are reported on `victim_rrpv` (way w in bits [w*M +: M]).
- R4: When `miss_inval` is nonzero (bit w set means way w holds no valid line), the victim is the lowest way whose bit is set, whatever the counters hold, and no aging takes place.
- R5: With `cfg_bimodal_fill` low, the victim way is written with 2^M−2 (2 for M=2) when the victim is accepted.
- R6: With `cfg_bimodal_fill` high, a fill writes 2^M−2 only when a 5-bit fill counter is zero, and writes the distant value otherwise. The counter is cleared by reset and advances on every accepted victim in either mode, so the first fill after reset and every 32nd fill after it get 2^M−2.
- R7: With `cfg_freq_promote` low, an accepted hit sets that way's counter to 0.
- R8: With `cfg_freq_promote` high, an accepted hit lowers that way's counter by one, and a counter already at 0 stays at 0.
- R9: A miss is accepted only in IDLE. `victim_valid` goes high two clock edges after the edge that accepts the miss. It then holds, with `victim_way` stable, until `victim_ready` is high.
- R10: A hit and a miss to the same set accepted at the same edge are applied hit first. `hit_ready` is low during SEARCH and in an OFFER cycle with `victim_ready` high. During OFFER without `victim_ready` it is high, and a hit taken then is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_freq_promote | input | 1 | 1: a hit lowers the counter by one; 0: a hit clears it |
| cfg_bimodal_fill | input | 1 | 1: bimodal insertion; 0: static insertion |
| hit_valid | input | 1 | Hit update request |
| hit_ready | output | 1 | Hit update accepted when high with hit_valid |
| hit_set | input | $clog2(SETS) | Set of the hit |
| hit_way | input | $clog2(WAYS) | Way of the hit |
| miss_valid | input | 1 | Miss request |
| miss_ready | output | 1 | Miss accepted when high with miss_valid |
| miss_set | input | $clog2(SETS) | Set of the miss |
| miss_inval | input | WAYS | Bit w set: way w holds no valid line |
| victim_valid | output | 1 | Victim way is presented |
| victim_ready | input | 1 | Victim taken; the insertion value is written |
| victim_way | output | $clog2(WAYS) | Chosen victim way |
| victim_rrpv | output | WAYS*M | Counters of the set after aging, way w in bits [w*M +: M] |

## Verification
The assertions assume that the controller keeps `hit_way` below WAYS and `hit_set` and `miss_set` below SETS. They also assume that `miss_inval` does not change while a miss is waiting to be accepted, and that the controller never raises `victim_ready` except in answer to `victim_valid`. The stimulus uses only in-range set and way numbers. It holds each request steady until its ready is seen at an edge, and it drives `victim_ready` only after it has seen `victim_valid`. Because of this, the only paths to a victim are through a real distant match or an invalid way, and the assertions on the victim choice depend on that.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_OFFER  = 2'd2
    } eng_state_t;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_HIT   = 2'd1,
        WR_AGED  = 2'd2,
        WR_FILL  = 2'd3
    } wr_src_t;

endpackage

// File: rtl/rrip_store.sv
module rrip_store #(
    parameter int SETS   = 16,
    parameter int WAYS   = 8,
    parameter int RRPV_W = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(SETS)-1:0]         wr_set,
    input  logic [WAYS*RRPV_W-1:0]          wr_row,
    input  logic [$clog2(SETS)-1:0]         rd_a_set,
    output logic [WAYS*RRPV_W-1:0]          rd_a_row,
    input  logic [$clog2(SETS)-1:0]         rd_b_set,
    output logic [WAYS*RRPV_W-1:0]          rd_b_row
);
    localparam int ROW_W = WAYS * RRPV_W;
    localparam logic [RRPV_W-1:0] DIST = {RRPV_W{1'b1}};

    logic [ROW_W-1:0] rows [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rows[s] <= {WAYS{DIST}};
            end
        end else if (wr_en) begin
            rows[wr_set] <= wr_row;
        end
    end

    assign rd_a_row = rows[rd_a_set];
    assign rd_b_row = rows[rd_b_set];

endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
    parameter int WAYS   = 8,
    parameter int RRPV_W = 2
) (
    input  logic [WAYS*RRPV_W-1:0]    row_i,
    input  logic [WAYS-1:0]           inval_i,
    output logic [WAYS*RRPV_W-1:0]    aged_o,
    output logic [$clog2(WAYS)-1:0]   victim_o,
    output logic                      found_o
);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [RRPV_W-1:0] DIST = {RRPV_W{1'b1}};

    logic [RRPV_W-1:0] fld    [WAYS];
    logic [RRPV_W-1:0] raised [WAYS];
    logic [WAYS*RRPV_W-1:0] raised_row;
    logic [WAYS-1:0]   at_dist;
    logic [WAYS-1:0]   sel_mask;
    logic [RRPV_W-1:0] peak;
    logic [RRPV_W-1:0] gap;
    logic              use_inval;

    // peak counter in the set decides how far all ways are raised
    always_comb begin
        peak = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (fld[w] > peak) peak = fld[w];
        end
        gap = DIST - peak;
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign fld[g]    = row_i[g*RRPV_W +: RRPV_W];
        assign raised[g] = fld[g] + gap;
        assign at_dist[g] = (raised[g] == DIST);
        assign raised_row[g*RRPV_W +: RRPV_W] = raised[g];
    end

    assign use_inval = |inval_i;
    assign sel_mask  = use_inval ? inval_i : at_dist;
    assign aged_o    = use_inval ? row_i : raised_row;
    assign found_o   = |sel_mask;

    // lowest set bit wins
    always_comb begin
        victim_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (sel_mask[w]) victim_o = WAY_W'(w);
        end
    end

endmodule

// File: rtl/rrip_bimodal.sv
module rrip_bimodal #(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance_i,
    output logic long_turn_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (advance_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign long_turn_o = (cnt_q == '0);

    // R6: counter steps once per fill and otherwise holds
    p_fill_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(cnt_q));

endmodule

// File: rtl/rrip_engine.sv
module rrip_engine #(
    parameter int SETS      = 16,
    parameter int WAYS      = 8,
    parameter int RRPV_W    = 2,
    parameter int BIMODAL_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_freq_promote,
    input  logic                         cfg_bimodal_fill,
    input  logic                         hit_valid,
    output logic                         hit_ready,
    input  logic [$clog2(SETS)-1:0]      hit_set,
    input  logic [$clog2(WAYS)-1:0]      hit_way,
    input  logic                         miss_valid,
    output logic                         miss_ready,
    input  logic [$clog2(SETS)-1:0]      miss_set,
    input  logic [WAYS-1:0]              miss_inval,
    output logic                         victim_valid,
    input  logic                         victim_ready,
    output logic [$clog2(WAYS)-1:0]      victim_way,
    output logic [WAYS*RRPV_W-1:0]       victim_rrpv
);
    import rrip_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int ROW_W = WAYS * RRPV_W;
    localparam logic [RRPV_W-1:0] DIST = {RRPV_W{1'b1}};
    localparam logic [RRPV_W-1:0] LONG = DIST - 1'b1;

    eng_state_t state_q, state_d;
    wr_src_t    wr_src;

    logic [SET_W-1:0] set_q;
    logic [WAYS-1:0]  inval_q;
    logic [WAY_W-1:0] victim_q;
    logic [ROW_W-1:0] vec_q;

    logic [ROW_W-1:0] hit_row, set_row;
    logic [ROW_W-1:0] hit_row_new, fill_row_new;
    logic [ROW_W-1:0] pick_aged;
    logic [WAY_W-1:0] pick_victim;
    logic             pick_found;
    logic             long_turn;
    logic [RRPV_W-1:0] ins_val;

    logic             wr_en;
    logic [SET_W-1:0] wr_set;
    logic [ROW_W-1:0] wr_row;

    logic hit_fire, miss_fire, fill_fire;

    assign hit_fire  = hit_valid && hit_ready;
    assign miss_fire = miss_valid && miss_ready;
    assign fill_fire = victim_valid && victim_ready;

    rrip_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .RRPV_W (RRPV_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .wr_row   (wr_row),
        .rd_a_set (hit_set),
        .rd_a_row (hit_row),
        .rd_b_set (set_q),
        .rd_b_row (set_row)
    );

    rrip_victim_pick #(
        .WAYS   (WAYS),
        .RRPV_W (RRPV_W)
    ) i_pick (
        .row_i    (set_row),
        .inval_i  (inval_q),
        .aged_o   (pick_aged),
        .victim_o (pick_victim),
        .found_o  (pick_found)
    );

    rrip_bimodal #(
        .CNT_W (BIMODAL_W)
    ) i_bimodal (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (fill_fire),
        .long_turn_o (long_turn)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (miss_fire) state_d = ST_SEARCH;
            ST_SEARCH: state_d = ST_OFFER;
            ST_OFFER:  if (victim_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and write-port selection
    always_comb begin
        miss_ready   = 1'b0;
        victim_valid = 1'b0;
        hit_ready    = 1'b1;
        wr_src       = hit_valid ? WR_HIT : WR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                miss_ready = 1'b1;
            end
            ST_SEARCH: begin
                hit_ready = 1'b0;
                wr_src    = WR_AGED;
            end
            ST_OFFER: begin
                victim_valid = 1'b1;
                if (victim_ready) begin
                    hit_ready = 1'b0;
                    wr_src    = WR_FILL;
                end
            end
            default: begin
                hit_ready = 1'b0;
                wr_src    = WR_NONE;
            end
        endcase
    end

    // hit promotion applied to the addressed way
    always_comb begin
        hit_row_new = hit_row;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == hit_way) begin
                if (!cfg_freq_promote) begin
                    hit_row_new[w*RRPV_W +: RRPV_W] = '0;
                end else if (hit_row[w*RRPV_W +: RRPV_W] != '0) begin
                    hit_row_new[w*RRPV_W +: RRPV_W] = hit_row[w*RRPV_W +: RRPV_W] - 1'b1;
                end
            end
        end
    end

    // insertion value for the victim way
    assign ins_val = (cfg_bimodal_fill && !long_turn) ? DIST : LONG;

    always_comb begin
        fill_row_new = set_row;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == victim_q) fill_row_new[w*RRPV_W +: RRPV_W] = ins_val;
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_set = set_q;
        wr_row = set_row;
        unique case (wr_src)
            WR_HIT: begin
                wr_en  = 1'b1;
                wr_set = hit_set;
                wr_row = hit_row_new;
            end
            WR_AGED: begin
                wr_en  = 1'b1;
                wr_row = pick_aged;
            end
            WR_FILL: begin
                wr_en  = 1'b1;
                wr_row = fill_row_new;
            end
            default: wr_en = 1'b0;
        endcase
    end

    // miss context and victim registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q    <= '0;
            inval_q  <= '0;
            victim_q <= '0;
            vec_q    <= {WAYS{DIST}};
        end else begin
            if (miss_fire) begin
                set_q   <= miss_set;
                inval_q <= miss_inval;
            end
            if (state_q == ST_SEARCH) begin
                victim_q <= pick_victim;
                vec_q    <= pick_aged;
            end
        end
    end

    assign victim_way  = victim_q;
    assign victim_rrpv = vec_q;

    // ---------------- assertions ----------------
    function automatic logic [RRPV_W-1:0] fld_of(input logic [ROW_W-1:0] r, input int idx);
        return r[idx*RRPV_W +: RRPV_W];
    endfunction

    logic lower_dist;
    always_comb begin
        lower_dist = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) < victim_q && fld_of(vec_q, w) == DIST) lower_dist = 1'b1;
        end
    end

    // R2: presented victim sits at distant and no lower way does
    p_victim_distant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && inval_q == '0) |-> fld_of(vec_q, int'(victim_q)) == DIST);
    p_victim_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && inval_q == '0) |-> !lower_dist);
    // R3: the search always yields a way to evict
    p_search_finds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> pick_found);
    // R4: an invalid way is chosen when any exists
    p_invalid_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && inval_q != '0) |-> inval_q[victim_q]);
    // R9: victim held stable until taken; no miss accepted while offering
    p_victim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !victim_ready) |=> (victim_valid && $stable(victim_way)));
    p_no_miss_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !miss_ready);
    p_victim_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_fire |=> !victim_valid ##1 victim_valid);
    // R10: hits blocked while the set is being searched
    p_search_blocks_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> !hit_ready);

endmodule

// File: tb/test_rrip_engine.sv
`timescale 1ns/1ps
module test_rrip_engine;
    localparam int SETS = 16;
    localparam int WAYS = 8;
    localparam int M    = 2;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int DIST = (1 << M) - 1;
    localparam int LONG = DIST - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_freq_promote = 1'b0;
    logic cfg_bimodal_fill = 1'b0;
    logic hit_valid = 1'b0;
    logic hit_ready;
    logic [SET_W-1:0] hit_set = '0;
    logic [WAY_W-1:0] hit_way = '0;
    logic miss_valid = 1'b0;
    logic miss_ready;
    logic [SET_W-1:0] miss_set = '0;
    logic [WAYS-1:0] miss_inval = '0;
    logic victim_valid;
    logic victim_ready = 1'b0;
    logic [WAY_W-1:0] victim_way;
    logic [WAYS*M-1:0] victim_rrpv;

    int checks = 0;
    int errors = 0;
    int fills  = 0;
    bit finished = 0;
    int model [SETS][WAYS];

    always #2.5 clk = ~clk;

    rrip_engine #(.SETS(SETS), .WAYS(WAYS), .RRPV_W(M), .BIMODAL_W(5)) i_rrip_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_freq_promote(cfg_freq_promote), .cfg_bimodal_fill(cfg_bimodal_fill),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_set(hit_set), .hit_way(hit_way),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_set(miss_set),
        .miss_inval(miss_inval), .victim_valid(victim_valid), .victim_ready(victim_ready),
        .victim_way(victim_way), .victim_rrpv(victim_rrpv)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model_hit(int s, int w);
        if (cfg_freq_promote) begin
            if (model[s][w] > 0) model[s][w] = model[s][w] - 1;
        end else begin
            model[s][w] = 0;
        end
    endfunction

    task automatic do_hit(input int s, input int w);
        @(negedge clk);
        hit_valid = 1'b1; hit_set = SET_W'(s); hit_way = WAY_W'(w);
        while (!hit_ready) @(negedge clk);
        @(posedge clk);
        model_hit(s, w);
        #1 hit_valid = 1'b0;
    endtask

    // miss with optional same-edge hit (sh_way>=0) and optional hit during offer (oh_set>=0)
    task automatic do_miss(input int s, input logic [WAYS-1:0] inv, input string req,
                           input int sh_way, input int oh_set);
        int row [WAYS];
        int vict;
        int ins;
        bit any;
        logic [WAYS*M-1:0] exp_vec;
        @(negedge clk);
        miss_valid = 1'b1; miss_set = SET_W'(s); miss_inval = inv;
        if (sh_way >= 0) begin
            hit_valid = 1'b1; hit_set = SET_W'(s); hit_way = WAY_W'(sh_way);
        end
        while (!miss_ready) @(negedge clk);
        @(posedge clk);
        if (sh_way >= 0) model_hit(s, sh_way);
        #1 miss_valid = 1'b0; hit_valid = 1'b0;
        // expected victim and aged row from the requirements
        for (int w = 0; w < WAYS; w++) row[w] = model[s][w];
        vict = -1;
        if (inv != '0) begin
            for (int w = WAYS - 1; w >= 0; w--) if (inv[w]) vict = w;
        end else begin
            any = 0;
            while (!any) begin
                for (int w = 0; w < WAYS; w++) if (row[w] == DIST) any = 1;
                if (!any) for (int w = 0; w < WAYS; w++) row[w] = row[w] + 1;
            end
            for (int w = WAYS - 1; w >= 0; w--) if (row[w] == DIST) vict = w;
        end
        for (int w = 0; w < WAYS; w++) begin
            exp_vec[w*M +: M] = M'(row[w]);
            model[s][w] = row[w];
        end
        @(negedge clk);
        check(victim_valid == 1'b0, "R9", "valid in search cycle", 64'(victim_valid), 0);
        check(hit_ready == 1'b0, "R10", "hit_ready in search", 64'(hit_ready), 0);
        check(miss_ready == 1'b0, "R9", "miss_ready in search", 64'(miss_ready), 0);
        @(negedge clk);
        check(victim_valid == 1'b1, "R9", "victim_valid", 64'(victim_valid), 1);
        check(victim_way == WAY_W'(vict), req, "victim_way", 64'(victim_way), 64'(vict));
        check(victim_rrpv == exp_vec, req, "victim_rrpv", 64'(victim_rrpv), 64'(exp_vec));
        if (oh_set >= 0) begin
            hit_valid = 1'b1; hit_set = SET_W'(oh_set); hit_way = '0;
            check(hit_ready == 1'b1, "R10", "hit_ready in offer", 64'(hit_ready), 1);
            @(posedge clk);
            model_hit(oh_set, 0);
            #1 hit_valid = 1'b0;
            @(negedge clk);
            check(victim_valid == 1'b1 && victim_way == WAY_W'(vict), "R9",
                  "victim held", 64'(victim_way), 64'(vict));
        end
        if (cfg_bimodal_fill) ins = (fills % 32 == 0) ? LONG : DIST;
        else ins = LONG;
        fills++;
        victim_ready = 1'b1;
        @(posedge clk);
        model[s][vict] = ins;
        #1 victim_ready = 1'b0;
    endtask

    task automatic t_reset;
        check(victim_valid == 1'b0, "R1", "victim_valid after reset", 64'(victim_valid), 0);
        check(miss_ready == 1'b1, "R1", "miss_ready after reset", 64'(miss_ready), 1);
        check(hit_ready == 1'b1, "R1", "hit_ready after reset", 64'(hit_ready), 1);
        do_miss(0, '0, "R1", -1, -1);
    endtask

    task automatic t_static_aging;
        cfg_bimodal_fill = 1'b0;
        for (int i = 0; i < WAYS; i++) do_miss(1, '0, "R2", -1, -1);
        do_miss(1, '0, "R3", -1, -1);   // all ways at long: aged by one
        do_miss(1, '0, "R5", -1, -1);
    endtask

    task automatic t_hit_priority;
        cfg_freq_promote = 1'b0;
        for (int i = 0; i < WAYS; i++) do_miss(7, '0, "R5", -1, -1);
        for (int w = 0; w < WAYS; w++) do_hit(7, w);
        do_miss(7, '0, "R7", -1, -1);   // all zero: full aging step
        do_miss(2, '0, "R2", -1, -1);
        do_hit(2, 0);
        do_miss(2, '0, "R7", -1, -1);
    endtask

    task automatic t_freq_priority;
        cfg_freq_promote = 1'b1;
        do_miss(6, '0, "R5", -1, -1);
        do_hit(6, 0);
        do_miss(6, '0, "R8", -1, -1);
        do_hit(6, 0);
        do_hit(6, 0);
        do_hit(6, 0);
        do_miss(6, '0, "R8", -1, -1);
        cfg_freq_promote = 1'b0;
    endtask

    task automatic t_invalid;
        do_miss(8, '0, "R2", -1, -1);
        do_miss(8, '0, "R2", -1, -1);
        do_miss(8, 8'b0010_0100, "R4", -1, -1);
        do_miss(8, 8'b0000_0010, "R4", -1, -1);
    endtask

    task automatic t_bimodal;
        cfg_bimodal_fill = 1'b1;
        for (int i = 0; i < 40; i++) do_miss(5, '0, "R6", -1, -1);
        for (int i = 0; i < 8; i++) do_miss(9, '0, "R6", -1, -1);
        cfg_bimodal_fill = 1'b0;
    endtask

    task automatic t_ordering;
        do_miss(4, '0, "R10", 0, -1);    // same-edge hit to way 0 wins first
        do_miss(4, '0, "R10", -1, 4);    // hit taken during offer
        do_miss(4, '0, "R10", -1, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) model[s][w] = DIST;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static_aging();
        t_hit_priority();
        t_freq_priority();
        t_invalid();
        t_bimodal();
        t_ordering();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule